// File: doc/BRIEF.md
# PCI Configuration Access Bridge

This block connects a CPU-side register bus to a PCI configuration-access port. Software can reach configuration space by two routes. The first is indirect: a full-word address register is loaded through I/O space, and the data port next to it then reads or writes the configuration location that the register points at. The second is a 4 MiB memory window. Inside it, the device is picked by the lowest set bit among CPU address bits 11 to 21, and the low 11 address bits select the function and register.

Each configuration access is sent downstream with a byte-enable mask, lane-placed write data and a write flag. The CPU request is held until the downstream target acknowledges. For a big-endian host, selected by a static parameter, halfword and word data on the memory window is byte-reversed in both directions. The block also folds the four interrupt pins of each device slot onto two host interrupt lines.

Top module: `cfgb_bridge`

## Requirements
- R1: A memory-space access (cpu_io=0) whose address lies in 0x8080_0000 to 0x80BF_FFFF goes to the configuration port. Memory-space addresses outside that range, and I/O-space addresses, never reach the port through the window.
- R2: In the window, the device index is the position i (0 to 10) of the lowest set bit among cpu_addr[21:11], or 11 if none of them is set. The configuration address is cpu_addr[10:0] | (i << 11).
- R3: cpu_size encodes 0 = byte, 1 = halfword, 2 = word (3 behaves as word). cfg_be bit n enables byte lane n (bits 8n+7:8n). A byte enables lane cpu_addr[1:0], a halfword enables lanes 1:0 or 3:2 according to cpu_addr[1], and a word enables all four lanes.
- R4: CPU write data is right-aligned and is moved up to the enabled lanes on cfg_wdata. Read data is taken from the enabled lanes, right-aligned, and zero-filled above the access size.
- R5: With BIG_ENDIAN=1, halfword and word data on the window path is byte-reversed on writes and on reads. Byte accesses and every indirect-port access are never reversed.
- R6: The address register sits at I/O address 0xCF8 and resets to zero. A word write stores the value, and a word read returns the last value stored. A byte or halfword access to 0xCF8 to 0xCFB has no effect and reads zero.
- R7: The data port at I/O 0xCFC to 0xCFF accepts all three sizes. Its configuration address is {addr_reg[23:2], cpu_addr[1:0]}.
- R8: While cfg_req is high and cfg_ack is low, cfg_req stays high and cfg_addr, cfg_be, cfg_we and cfg_wdata stay unchanged. cpu_ack rises in the cycle after cfg_ack is sampled and lasts exactly one cycle. A port access with a target delay of d cycles takes 2+d cycles.
- R9: An access that hits neither window completes with cpu_ack after one cycle and read data zero, and it raises no cfg_req.
- R10: Pin p (0 to 3) of slot s is routed to line 9 if (p+s) mod 2 = 0, and to line 11 otherwise. Each line is the OR of every pin routed to it. The pin is dev_irq[4s+p].
- R11: Out of reset, cpu_ack and cfg_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | CPU access request, held until cpu_ack |
| cpu_io | input | 1 | 1 = I/O space, 0 = memory space |
| cpu_we | input | 1 | 1 = write |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 2 | Access size code |
| cpu_wdata | input | 32 | Right-aligned write data |
| cpu_ack | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | 32 | Right-aligned read data, valid with cpu_ack |
| cfg_req | output | 1 | Configuration request, held until cfg_ack |
| cfg_we | output | 1 | Configuration write flag |
| cfg_addr | output | 24 | Configuration byte address |
| cfg_be | output | 4 | Byte-lane enables |
| cfg_wdata | output | 32 | Lane-placed write data |
| cfg_ack | input | 1 | Target acknowledge |
| cfg_rdata | input | 32 | Target read data, valid with cfg_ack |
| dev_irq | input | 32 | Device interrupt pins, 4 per slot |
| irq_line9 | output | 1 | Host interrupt line 9 |
| irq_line11 | output | 1 | Host interrupt line 11 |

## Verification
The bench works through the device-index search with one select bit, with several select bits (only the lowest one may count), with the top bit alone, and with no bit set. A search that took the highest bit, or that wrapped to zero when no bit is set, would send the access to the wrong slot. It drives halfword and byte accesses at upper offsets and fills the unselected read lanes with junk. A lane shifter or masker that slipped would return that junk or store bytes in the wrong place. Swapping is checked on the window and against the indirect port and byte accesses, so a swap applied on the wrong path is caught. Partial-width accesses to the address register must leave it intact, and a slow target must not make cpu_ack early, doubled or missing.

// File: rtl/cfgb_pkg.sv
`timescale 1ns/1ps
package cfgb_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_AREG = 2'd1,
      TGT_PORT = 2'd2,
      TGT_WIN  = 2'd3
   } tgt_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_DONE = 2'd2
   } st_e;

   // first byte lane touched by an access of this size at this offset
   function automatic logic [1:0] lane_base(acc_size_e sz, logic [1:0] off);
      case (sz)
         SZ_BYTE: return off;
         SZ_HALF: return {off[1], 1'b0};
         default: return 2'b00;
      endcase
   endfunction

   function automatic logic [31:0] size_mask(acc_size_e sz);
      case (sz)
         SZ_BYTE: return 32'h0000_00FF;
         SZ_HALF: return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   // trims to the access size and reverses byte order within it
   function automatic logic [31:0] reorder(logic [31:0] v, acc_size_e sz);
      case (sz)
         SZ_BYTE: return {24'h0, v[7:0]};
         SZ_HALF: return {16'h0, v[7:0], v[15:8]};
         default: return {v[7:0], v[15:8], v[23:16], v[31:24]};
      endcase
   endfunction

endpackage

// File: rtl/cfgb_decode.sv
`timescale 1ns/1ps
module cfgb_decode
   import cfgb_pkg::*;
#(
   parameter logic [31:0] WIN_BASE = 32'h8080_0000,
   parameter int          WIN_BITS = 22,
   parameter int          SEL_LO   = 11,
   parameter int          SEL_N    = 11,
   parameter logic [31:0] AREG_IO  = 32'h0000_0CF8,
   parameter logic [31:0] PORT_IO  = 32'h0000_0CFC,
   parameter int          CFG_AW   = 24
) (
   input  logic              cpu_io,
   input  logic [31:0]       cpu_addr,
   input  acc_size_e         cpu_size,
   input  logic [CFG_AW-1:2] areg_hi,
   output tgt_e              tgt,
   output logic [CFG_AW-1:0] xaddr
);
   localparam int IW  = $clog2(SEL_N + 1);
   localparam int DAW = SEL_LO + IW;

   logic             win_hit, areg_hit, port_hit;
   logic [SEL_N-1:0] sel;
   logic [SEL_N:0]   below;
   logic [SEL_N-1:0] first;
   logic [IW-1:0]    idx;
   logic [DAW-1:0]   direct;

   assign win_hit  = !cpu_io && (cpu_addr[31:WIN_BITS] == WIN_BASE[31:WIN_BITS]);
   assign areg_hit = cpu_io && (cpu_addr[31:2] == AREG_IO[31:2]);
   assign port_hit = cpu_io && (cpu_addr[31:2] == PORT_IO[31:2]);

   // lowest-set-bit search over the select field, as a prefix chain
   assign sel      = cpu_addr[SEL_LO +: SEL_N];
   assign below[0] = 1'b0;
   for (genvar i = 0; i < SEL_N; i++) begin : g_pri
      assign below[i+1] = below[i] | sel[i];
      assign first[i]   = sel[i] & ~below[i];
   end

   always_comb begin
      idx = IW'(SEL_N);
      for (int i = 0; i < SEL_N; i++) begin
         if (first[i]) idx = IW'(i);
      end
   end

   assign direct = {idx, cpu_addr[SEL_LO-1:0]};

   always_comb begin
      if (win_hit)       tgt = TGT_WIN;
      else if (port_hit) tgt = TGT_PORT;
      else if (areg_hit && (cpu_size == SZ_WORD)) tgt = TGT_AREG;
      else               tgt = TGT_NONE;
   end

   always_comb begin
      if (win_hit) xaddr = CFG_AW'(direct);
      else         xaddr = {areg_hi, cpu_addr[1:0]};
   end

endmodule

// File: rtl/cfgb_lane.sv
`timescale 1ns/1ps
module cfgb_lane
   import cfgb_pkg::*;
(
   input  acc_size_e   w_sz,
   input  logic [1:0]  w_off,
   input  logic        w_swap,
   input  logic [31:0] w_val,
   output logic [3:0]  w_be,
   output logic [31:0] w_bus,
   input  acc_size_e   r_sz,
   input  logic [1:0]  r_off,
   input  logic        r_swap,
   input  logic [31:0] r_bus,
   output logic [31:0] r_val
);
   logic [1:0]  w_base, r_base;
   logic [31:0] w_fit, r_raw;

   always_comb begin
      w_base = lane_base(w_sz, w_off);
      w_fit  = w_swap ? reorder(w_val, w_sz) : (w_val & size_mask(w_sz));
      w_bus  = w_fit << {w_base, 3'b000};
      case (w_sz)
         SZ_BYTE: w_be = 4'b0001 << w_base;
         SZ_HALF: w_be = 4'b0011 << w_base;
         default: w_be = 4'b1111;
      endcase
   end

   always_comb begin
      r_base = lane_base(r_sz, r_off);
      r_raw  = (r_bus >> {r_base, 3'b000}) & size_mask(r_sz);
      r_val  = r_swap ? reorder(r_raw, r_sz) : r_raw;
   end

endmodule

// File: rtl/cfgb_irq_route.sv
`timescale 1ns/1ps
module cfgb_irq_route #(
   parameter int SLOTS = 8,
   parameter int PINS  = 4
) (
   input  logic [SLOTS*PINS-1:0] dev_irq,
   output logic                  line_even,
   output logic                  line_odd
);
   logic [SLOTS*PINS-1:0] to_odd;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      for (genvar p = 0; p < PINS; p++) begin : g_pin
         assign to_odd[s*PINS+p] = ((s + p) % 2) == 1;
      end
   end

   assign line_odd  = |(dev_irq & to_odd);
   assign line_even = |(dev_irq & ~to_odd);

endmodule

// File: rtl/cfgb_bridge.sv
`timescale 1ns/1ps
module cfgb_bridge
   import cfgb_pkg::*;
#(
   parameter logic [31:0] WIN_BASE   = 32'h8080_0000,
   parameter int          WIN_BITS   = 22,
   parameter int          SEL_LO     = 11,
   parameter int          SEL_N      = 11,
   parameter logic [31:0] AREG_IO    = 32'h0000_0CF8,
   parameter logic [31:0] PORT_IO    = 32'h0000_0CFC,
   parameter int          CFG_AW     = 24,
   parameter int          SLOTS      = 8,
   parameter int          PINS       = 4,
   parameter bit          BIG_ENDIAN = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cpu_req,
   input  logic                  cpu_io,
   input  logic                  cpu_we,
   input  logic [31:0]           cpu_addr,
   input  logic [1:0]            cpu_size,
   input  logic [31:0]           cpu_wdata,
   output logic                  cpu_ack,
   output logic [31:0]           cpu_rdata,
   output logic                  cfg_req,
   output logic                  cfg_we,
   output logic [CFG_AW-1:0]     cfg_addr,
   output logic [3:0]            cfg_be,
   output logic [31:0]           cfg_wdata,
   input  logic                  cfg_ack,
   input  logic [31:0]           cfg_rdata,
   input  logic [SLOTS*PINS-1:0] dev_irq,
   output logic                  irq_line9,
   output logic                  irq_line11
);
   localparam int IW = $clog2(SEL_N + 1);

   // elaboration-time parameter checks
   if (SEL_LO + SEL_N > WIN_BITS || WIN_BITS > 31) begin : g_bad_win
      $error("cfgb_bridge: select field does not fit the window");
   end
   if (CFG_AW < SEL_LO + IW || CFG_AW > 32) begin : g_bad_aw
      $error("cfgb_bridge: CFG_AW cannot hold a translated address");
   end
   if (AREG_IO[1:0] != 2'b00 || PORT_IO[1:0] != 2'b00 || AREG_IO == PORT_IO) begin : g_bad_io
      $error("cfgb_bridge: I/O registers must be distinct and word aligned");
   end
   if (WIN_BASE[WIN_BITS-1:0] != '0) begin : g_bad_base
      $error("cfgb_bridge: window base must be aligned to its size");
   end

   acc_size_e         sz;
   tgt_e              tgt;
   logic [CFG_AW-1:0] xaddr;
   logic              win_swap;
   logic [3:0]        w_be;
   logic [31:0]       w_bus, r_val;

   st_e               st;
   logic [31:0]       areg_q, rdata_q;
   logic [CFG_AW-1:0] addr_q;
   logic [3:0]        be_q;
   logic [31:0]       wdata_q;
   logic              we_q, swap_q;
   acc_size_e         sz_q;
   logic [1:0]        off_q;

   assign sz = acc_size_e'(cpu_size);

   cfgb_decode #(
      .WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS), .SEL_LO(SEL_LO), .SEL_N(SEL_N),
      .AREG_IO(AREG_IO), .PORT_IO(PORT_IO), .CFG_AW(CFG_AW)
   ) u_decode (
      .cpu_io  (cpu_io),
      .cpu_addr(cpu_addr),
      .cpu_size(sz),
      .areg_hi (areg_q[CFG_AW-1:2]),
      .tgt     (tgt),
      .xaddr   (xaddr)
   );

   // host byte order picks whether the window path reorders data
   if (BIG_ENDIAN) begin : g_big
      assign win_swap = (tgt == TGT_WIN);
   end else begin : g_little
      assign win_swap = 1'b0;
   end

   cfgb_lane u_lane (
      .w_sz  (sz),
      .w_off (cpu_addr[1:0]),
      .w_swap(win_swap),
      .w_val (cpu_wdata),
      .w_be  (w_be),
      .w_bus (w_bus),
      .r_sz  (sz_q),
      .r_off (off_q),
      .r_swap(swap_q),
      .r_bus (cfg_rdata),
      .r_val (r_val)
   );

   cfgb_irq_route #(.SLOTS(SLOTS), .PINS(PINS)) u_irq (
      .dev_irq  (dev_irq),
      .line_even(irq_line9),
      .line_odd (irq_line11)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         areg_q  <= '0;
         rdata_q <= '0;
         addr_q  <= '0;
         be_q    <= '0;
         wdata_q <= '0;
         we_q    <= 1'b0;
         swap_q  <= 1'b0;
         sz_q    <= SZ_BYTE;
         off_q   <= 2'b00;
      end else begin
         case (st)
            ST_IDLE: begin
               if (cpu_req) begin
                  sz_q    <= sz;
                  off_q   <= cpu_addr[1:0];
                  swap_q  <= win_swap;
                  we_q    <= cpu_we;
                  addr_q  <= xaddr;
                  be_q    <= w_be;
                  wdata_q <= cpu_we ? w_bus : 32'h0;
                  rdata_q <= '0;
                  case (tgt)
                     TGT_WIN, TGT_PORT: st <= ST_WAIT;
                     TGT_AREG: begin
                        if (cpu_we) areg_q  <= cpu_wdata;
                        else        rdata_q <= areg_q;
                        st <= ST_DONE;
                     end
                     default: st <= ST_DONE;
                  endcase
               end
            end
            ST_WAIT: begin
               if (cfg_ack) begin
                  if (!we_q) rdata_q <= r_val;
                  st <= ST_DONE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign cfg_req   = (st == ST_WAIT);
   assign cfg_we    = we_q;
   assign cfg_addr  = addr_q;
   assign cfg_be    = be_q;
   assign cfg_wdata = wdata_q;
   assign cpu_ack   = (st == ST_DONE);
   assign cpu_rdata = rdata_q;

   // R8: request and its fields hold until the target answers
   assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req && !cfg_ack |=> cfg_req && $stable(cfg_addr) && $stable(cfg_be)
                              && $stable(cfg_we) && $stable(cfg_wdata));

   // R8: target acknowledge is followed by CPU completion, request dropped
   assert_ack_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req && cfg_ack |=> cpu_ack && !cfg_req);

   // R8: completion strobe lasts one cycle
   assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |=> !cpu_ack);

   // R3: only legal lane patterns reach the port
   assert_be_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |-> (cfg_be inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF}));

   // R10: no pin asserted means both host lines quiet
   assert_quiet_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_irq == '0) |-> (!irq_line9 && !irq_line11));

endmodule

// File: tb/sim_cfgb_bridge.sv
`timescale 1ns/1ps
module sim_cfgb_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_io = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [1:0]  cpu_size = '0;
   logic        cpu_ack;
   logic [31:0] cpu_rdata;
   logic        cfg_req, cfg_we;
   logic [23:0] cfg_addr;
   logic [3:0]  cfg_be;
   logic [31:0] cfg_wdata;
   logic        cfg_ack = 1'b0;
   logic [31:0] cfg_rdata = '0;
   logic [31:0] dev_irq = '0;
   logic        irq_line9, irq_line11;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   cfgb_bridge #(.BIG_ENDIAN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_io(cpu_io), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_size(cpu_size), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
      .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata),
      .dev_irq(dev_irq), .irq_line9(irq_line9), .irq_line11(irq_line11)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // ---------------- reference helpers ----------------
   function automatic logic [31:0] ref_swap(logic [31:0] v, int sz);
      if (sz == 0) return {24'h0, v[7:0]};
      if (sz == 1) return {16'h0, v[7:0], v[15:8]};
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   function automatic int dev_index(logic [31:0] a);
      for (int i = 0; i < 11; i++) if (a[11+i]) return i;
      return 11;
   endfunction

   // ---------------- configuration target model ----------------
   logic [7:0]  mem [int unsigned];
   int          tgt_dly = 0;
   int          wait_cnt = 0;
   bit          in_cfg = 0, seen_cfg = 0;
   logic [23:0] obs_addr;
   logic [3:0]  obs_be;
   logic        obs_we;
   logic [31:0] obs_wdata;

   always @(negedge clk) begin
      if (cfg_ack) begin
         cfg_ack = 1'b0;
      end else if (cfg_req) begin
         if (!in_cfg) begin
            in_cfg = 1; seen_cfg = 1;
            obs_addr = cfg_addr; obs_be = cfg_be; obs_we = cfg_we; obs_wdata = cfg_wdata;
         end else begin
            chk("R8 fields held while waiting", {cfg_addr, cfg_be, cfg_we, 3'b0},
                {obs_addr, obs_be, obs_we, 3'b0});
         end
         if (wait_cnt == tgt_dly) begin
            wait_cnt = 0;
            for (int b = 0; b < 4; b++) begin
               int unsigned a;
               a = {8'h0, cfg_addr[23:2], 2'b00} + b;
               if (cfg_be[b]) begin
                  if (cfg_we) mem[a] = cfg_wdata[8*b +: 8];
                  cfg_rdata[8*b +: 8] = mem.exists(a) ? mem[a] : 8'h00;
               end else begin
                  cfg_rdata[8*b +: 8] = 8'hEE;
               end
            end
            cfg_ack = 1'b1;
            in_cfg = 0;
         end else begin
            wait_cnt++;
         end
      end
   end

   // ---------------- interrupt reference, every clock ----------------
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         logic e9, e11;
         e9 = 0; e11 = 0;
         for (int s = 0; s < 8; s++)
            for (int p = 0; p < 4; p++)
               if (dev_irq[4*s+p]) begin
                  if (((s + p) & 1) == 1) e11 = 1; else e9 = 1;
               end
         chk("R10 host lines", {30'h0, irq_line11, irq_line9}, {30'h0, e11, e9});
      end
   end

   // ---------------- CPU access task ----------------
   task automatic xfer(input bit io, input bit we, input logic [31:0] a, input int sz,
                       input logic [31:0] wd, output logic [31:0] rd, output int lat);
      seen_cfg  = 0;
      cpu_io    = io; cpu_we = we; cpu_addr = a; cpu_size = 2'(sz); cpu_wdata = wd;
      cpu_req   = 1'b1;
      lat = 0;
      do begin @(negedge clk); lat++; end while (!cpu_ack && lat < 40);
      rd = cpu_rdata;
      cpu_req = 1'b0;
      @(negedge clk);
      chk("R8 single-cycle cpu_ack", {31'h0, cpu_ack}, 32'h0);
   endtask

   task automatic expect_cfg(input string tag, input logic [23:0] ea, input logic [3:0] ebe,
                             input bit ewe, input logic [31:0] ewd);
      chk({tag, " port used"}, {31'h0, seen_cfg}, 32'h1);
      chk({tag, " address"}, {8'h0, obs_addr}, {8'h0, ea});
      chk({tag, " enables"}, {28'h0, obs_be}, {28'h0, ebe});
      chk({tag, " write flag"}, {31'h0, obs_we}, {31'h0, ewe});
      if (ewe) chk({tag, " write data"}, obs_wdata, ewd);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(8 * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] rd, areg;
      int lat;

      repeat (3) @(negedge clk);
      chk("R11 cpu_ack at reset", {31'h0, cpu_ack}, 32'h0);
      chk("R11 cfg_req at reset", {31'h0, cfg_req}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: address register
      xfer(1, 0, 32'hCF8, 2, 0, rd, lat);
      chk("R6 reset value", rd, 32'h0);
      areg = 32'h8012_3458;
      xfer(1, 1, 32'hCF8, 2, areg, rd, lat);
      xfer(1, 0, 32'hCF8, 2, 0, rd, lat);
      chk("R6 read back", rd, areg);
      xfer(1, 1, 32'hCF9, 0, 32'hFF, rd, lat);
      xfer(1, 1, 32'hCFA, 1, 32'hFFFF, rd, lat);
      xfer(1, 0, 32'hCF8, 2, 0, rd, lat);
      chk("R6 partial writes ignored", rd, areg);
      xfer(1, 0, 32'hCF8, 0, 0, rd, lat);
      chk("R6 byte read is zero", rd, 32'h0);
      chk("R6 byte read no port cycle", {31'h0, seen_cfg}, 32'h0);

      // R7: indirect data port, never swapped (R5)
      xfer(1, 1, 32'hCFC, 2, 32'hDEAD_BEEF, rd, lat);
      expect_cfg("R7 word write", 24'h12_3458, 4'hF, 1, 32'hDEAD_BEEF);
      xfer(1, 0, 32'hCFE, 0, 0, rd, lat);
      expect_cfg("R7 byte read", 24'h12_345A, 4'h4, 0, 0);
      chk("R4 indirect byte data", rd, 32'h0000_00AD);
      xfer(1, 1, 32'hCFE, 1, 32'h1234, rd, lat);
      expect_cfg("R5 indirect half unswapped", 24'h12_345A, 4'hC, 1, 32'h1234_0000);
      xfer(1, 0, 32'hCFC, 2, 0, rd, lat);
      chk("R5 indirect word read unswapped", rd, 32'h1234_BEEF);

      // R2: device index search
      xfer(0, 0, 32'h8080_0810, 2, 0, rd, lat);
      expect_cfg("R2 bit11", 24'(32'h010 | (dev_index(32'h8080_0810) << 11)), 4'hF, 0, 0);
      xfer(0, 0, 32'h8080_A024, 2, 0, rd, lat);
      expect_cfg("R2 lowest of bits 13 and 15", 24'h00_1024, 4'hF, 0, 0);
      xfer(0, 0, 32'h8080_0004, 2, 0, rd, lat);
      expect_cfg("R2 none set saturates", 24'h00_5804, 4'hF, 0, 0);
      xfer(0, 0, 32'h80A0_0008, 2, 0, rd, lat);
      expect_cfg("R2 bit21 only", 24'(32'h008 | (10 << 11)), 4'hF, 0, 0);

      // R5/R4/R3: window data with big-endian host
      xfer(0, 1, 32'h8080_0800, 2, 32'h1122_3344, rd, lat);
      expect_cfg("R5 window word write", 24'h0, 4'hF, 1, ref_swap(32'h1122_3344, 2));
      xfer(0, 0, 32'h8080_0800, 2, 0, rd, lat);
      chk("R5 window word read", rd, 32'h1122_3344);
      xfer(0, 1, 32'h8080_0802, 1, 32'hABCD, rd, lat);
      expect_cfg("R3 window half write", 24'h2, 4'hC, 1, 32'hCDAB_0000);
      xfer(0, 0, 32'h8080_0802, 1, 0, rd, lat);
      chk("R4 window half read", rd, 32'h0000_ABCD);
      xfer(0, 1, 32'h8080_0801, 0, 32'h5A, rd, lat);
      expect_cfg("R5 window byte write", 24'h1, 4'h2, 1, 32'h0000_5A00);
      xfer(0, 0, 32'h8080_0801, 0, 0, rd, lat);
      chk("R5 window byte read", rd, 32'h0000_005A);
      xfer(0, 0, 32'h8080_0800, 2, 0, rd, lat);
      chk("R4 merged word", rd, ref_swap(32'hCDAB_5A11, 2));

      // R1/R9: outside the windows
      xfer(0, 0, 32'h80C0_0000, 2, 0, rd, lat);
      chk("R1 above window no port", {31'h0, seen_cfg}, 32'h0);
      chk("R9 above window data", rd, 32'h0);
      chk("R9 one-cycle completion", lat, 1);
      xfer(0, 0, 32'h807F_FFFC, 2, 0, rd, lat);
      chk("R1 below window no port", {31'h0, seen_cfg}, 32'h0);
      xfer(1, 0, 32'h8080_0800, 2, 0, rd, lat);
      chk("R1 I/O space ignores window", {31'h0, seen_cfg}, 32'h0);
      xfer(1, 1, 32'hCF0, 2, 32'h1, rd, lat);
      chk("R9 unmapped I/O", {31'h0, seen_cfg}, 32'h0);

      // R8: slow target
      xfer(0, 0, 32'h8080_0800, 2, 0, rd, lat);
      chk("R8 latency delay 0", lat, 2);
      tgt_dly = 3;
      xfer(0, 0, 32'h8080_0800, 2, 0, rd, lat);
      chk("R8 latency delay 3", lat, 5);
      chk("R8 data after wait", rd, 32'h115A_ABCD);
      tgt_dly = 0;

      // R10: interrupt patterns (compared every clock above)
      dev_irq = 32'h0000_0001; repeat (3) @(negedge clk);
      dev_irq = 32'h0000_0010; repeat (3) @(negedge clk);
      dev_irq = 32'h0000_4000; repeat (3) @(negedge clk);
      dev_irq = 32'h0000_0100; repeat (3) @(negedge clk);
      dev_irq = 32'h8000_0002; repeat (3) @(negedge clk);
      dev_irq = 32'hFFFF_FFFF; repeat (3) @(negedge clk);
      dev_irq = 32'h0;         repeat (3) @(negedge clk);

      finish_run();
   end

endmodule